// File: doc/BRIEF.md
# SDRAM Mode Command Engine

This block takes one command word at a time and turns it into the control pin pattern for up to two attached SDRAM devices. It covers chip select, row strobe, column strobe, write enable, clock enable, address and bank address. A command word carries four fields:
- a 3-bit operation code;
- a per-device target mask;
- a repeat count, used only by auto-refresh;
- a mode-register value.

The engine places the command on the pins for one cycle. It then holds off until the programmed minimum delay for that command has elapsed. Busy stays high for the whole of that time.

The block is used during device bring-up and for power management. Software-style sequences use it to enable the clock, precharge all banks, run a burst of auto-refreshes, load the mode register, and enter or leave self-refresh and power-down. Each delay is a 4-bit field that holds the cycle count minus one. Whenever no command is on the pins, the engine drives a no-operation with both chip selects asserted.

Top module: `sdram_cmd_engine`

## Requirements
- R1: After reset, and in every cycle where busy is low, the pins carry a NOP (row, column and write strobes all high) with both chip selects low. After reset, clock enable is low for both devices, busy is low and the error flag is low.
- R2: An accepted command appears on the pins for one cycle, in the cycle after the write. Busy is high from that cycle until the command's delay has elapsed. Between issues the pins carry a NOP with both chip selects low. The strobe patterns (row, column, write) are:
  - NOP: 111
  - precharge all: 010
  - auto-refresh: 001
  - load mode: 000
  - self-refresh: 001
- R3: Chip select n of an issued command is low exactly when target bit n is set. A write with both target bits clear is ignored, as is a write with operation code 7. An ignored write leaves the pins, busy, clock enable and the error flag unchanged.
- R4: Auto-refresh (code 3) issues as many refresh commands as the repeat count says, and a count of 0 issues one. Successive refreshes are spaced by tRC cycles. Busy stays high until tRC has passed after the last refresh.
- R5: Precharge all (code 2) drives address bit 10 high, and busy stays high for tRP cycles from the issue cycle.
- R6: Load mode (code 4) drives the mode-register value on the address lines with bank address 0. Busy stays high for tMRD cycles from the issue cycle. Every other command drives address 0.
- R7: Clock enable (code 1) and normal mode (code 0) raise clock enable for the targeted devices. Self-refresh (code 5) and power-down (code 6) lower it. The new level is already present in the issue cycle, and untargeted devices keep their level.
- R8: Normal mode aimed at a device that is in self-refresh keeps busy high for tXSR cycles from the issue cycle. Clock enable, power-down, self-refresh, and normal mode with no targeted device in self-refresh each hold busy for the issue cycle only.
- R9: A write while busy is rejected and leaves the ongoing command's pin sequence unaltered. It sets an error flag that stays high until reset.
- R10: Each delay input holds its cycle count minus one, so a field value f gives a spacing of f+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_mode_i | input | 3 | Operation code |
| cmd_target_i | input | DEV_N | Device target mask |
| cmd_rep_i | input | RFS_W | Auto-refresh repeat count |
| cmd_mrd_i | input | ADDR_W | Mode-register value |
| t_rc_i | input | T_W | Row-cycle time minus one |
| t_rp_i | input | T_W | Row-precharge time minus one |
| t_mrd_i | input | T_W | Mode-register-to-active time minus one |
| t_xsr_i | input | T_W | Exit-self-refresh time minus one |
| busy_o | output | 1 | Command in progress |
| err_o | output | 1 | Sticky write-while-busy flag |
| cs_n_o | output | DEV_N | Per-device chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | DEV_N | Per-device clock enable |
| addr_o | output | ADDR_W | Address lines |
| ba_o | output | BA_W | Bank address |

## Verification
A write sampled at one clock edge shows its command on the pins one cycle later, since the engine has a single state register. Each following cycle is then predetermined: the delay cycles for the command, the repeated issues, and finally the first idle cycle, in which busy is low. The driver computes this whole cycle list from the operation code, the target mask, the repeat count and the delay fields. It queues the list right after the accepting edge. The monitor takes one entry per falling edge and compares the full pin set, so every result is checked in exactly the cycle it is due.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef enum logic [2:0] {
    OP_NORMAL = 3'd0,
    OP_CLKEN  = 3'd1,
    OP_PALL   = 3'd2,
    OP_AREF   = 3'd3,
    OP_LOAD   = 3'd4,
    OP_SREF   = 3'd5,
    OP_PDOWN  = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } eng_state_e;

  // {ras_n, cas_n, we_n}
  localparam logic [2:0] PIN_NOP  = 3'b111;
  localparam logic [2:0] PIN_PALL = 3'b010;
  localparam logic [2:0] PIN_AREF = 3'b001;
  localparam logic [2:0] PIN_LOAD = 3'b000;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
#(
  parameter int T_W = 4
) (
  input  op_e            op_i,
  input  logic           xsr_i,
  input  logic [T_W-1:0] t_rc_i,
  input  logic [T_W-1:0] t_rp_i,
  input  logic [T_W-1:0] t_mrd_i,
  input  logic [T_W-1:0] t_xsr_i,
  output logic [2:0]     pins_o,
  output logic [T_W-1:0] wait_o
);
  always_comb begin
    pins_o = PIN_NOP;
    wait_o = '0;
    unique case (op_i)
      OP_PALL: begin pins_o = PIN_PALL; wait_o = t_rp_i;  end
      OP_AREF: begin pins_o = PIN_AREF; wait_o = t_rc_i;  end
      OP_LOAD: begin pins_o = PIN_LOAD; wait_o = t_mrd_i; end
      OP_SREF: pins_o = PIN_AREF; // self-refresh shares strobes, CKE low
      OP_NORMAL: if (xsr_i) wait_o = t_xsr_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_cmd_timer.sv
module sdram_cmd_timer #(
  parameter int T_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [T_W-1:0] val_i,
  output logic           last_o
);
  logic [T_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == T_W'(1));

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R10
endmodule

// File: rtl/sdram_cmd_engine.sv
module sdram_cmd_engine
  import sdram_cmd_pkg::*;
#(
  parameter int DEV_N  = 2,
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int T_W    = 4,
  parameter int RFS_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_mode_i,
  input  logic [DEV_N-1:0]  cmd_target_i,
  input  logic [RFS_W-1:0]  cmd_rep_i,
  input  logic [ADDR_W-1:0] cmd_mrd_i,
  input  logic [T_W-1:0]    t_rc_i,
  input  logic [T_W-1:0]    t_rp_i,
  input  logic [T_W-1:0]    t_mrd_i,
  input  logic [T_W-1:0]    t_xsr_i,
  output logic              busy_o,
  output logic              err_o,
  output logic [DEV_N-1:0]  cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [DEV_N-1:0]  cke_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);
  localparam int AP_BIT = 10;

  eng_state_e        state_q;
  op_e               op_q;
  logic [DEV_N-1:0]  tgt_q;
  logic [ADDR_W-1:0] mrd_q;
  logic [RFS_W-1:0]  rep_q;
  logic              xsr_q;
  logic              err_q;
  logic [DEV_N-1:0]  cke_q;
  logic [DEV_N-1:0]  sref_q;

  logic              accept, reject, issuing;
  logic [2:0]        dec_pins;
  logic [T_W-1:0]    dec_wait;
  logic              tmr_last;
  op_e               op_in;

  assign op_in   = op_e'(cmd_mode_i);
  assign accept  = cmd_valid_i && (state_q == ST_IDLE) && (|cmd_target_i) && (op_in != OP_RSVD);
  assign reject  = cmd_valid_i && (state_q != ST_IDLE);
  assign issuing = (state_q == ST_ISSUE);

  sdram_cmd_decode #(.T_W(T_W)) i_decode (
    .op_i    (op_q),
    .xsr_i   (xsr_q),
    .t_rc_i  (t_rc_i),
    .t_rp_i  (t_rp_i),
    .t_mrd_i (t_mrd_i),
    .t_xsr_i (t_xsr_i),
    .pins_o  (dec_pins),
    .wait_o  (dec_wait)
  );

  sdram_cmd_timer #(.T_W(T_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (issuing),
    .val_i  (dec_wait),
    .last_o (tmr_last)
  );

  // Sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NORMAL;
      tgt_q   <= '0;
      mrd_q   <= '0;
      rep_q   <= '0;
      xsr_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ISSUE;
          op_q    <= op_in;
          tgt_q   <= cmd_target_i;
          mrd_q   <= cmd_mrd_i;
          rep_q   <= (op_in == OP_AREF && cmd_rep_i != '0) ? cmd_rep_i - RFS_W'(1) : '0;
          xsr_q   <= (op_in == OP_NORMAL) && (|(sref_q & cmd_target_i));
        end
        ST_ISSUE: begin
          if (dec_wait != '0) state_q <= ST_WAIT;
          else if (rep_q != '0) rep_q <= rep_q - 1'b1;
          else state_q <= ST_IDLE;
        end
        ST_WAIT: if (tmr_last) begin
          if (rep_q != '0) begin
            state_q <= ST_ISSUE;
            rep_q   <= rep_q - 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Per-device clock enable and self-refresh tracking
  for (genvar g = 0; g < DEV_N; g++) begin : g_dev
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cke_q[g]  <= 1'b0;
        sref_q[g] <= 1'b0;
      end else if (accept && cmd_target_i[g]) begin
        unique case (op_in)
          OP_NORMAL: begin cke_q[g] <= 1'b1; sref_q[g] <= 1'b0; end
          OP_CLKEN:  cke_q[g] <= 1'b1;
          OP_SREF:   begin cke_q[g] <= 1'b0; sref_q[g] <= 1'b1; end
          OP_PDOWN:  cke_q[g] <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (reject) err_q <= 1'b1;
  end

  // Pin drive
  always_comb begin
    cs_n_o = '0;
    {ras_n_o, cas_n_o, we_n_o} = PIN_NOP;
    addr_o = '0;
    if (issuing) begin
      cs_n_o = ~tgt_q;
      {ras_n_o, cas_n_o, we_n_o} = dec_pins;
      if (op_q == OP_LOAD) addr_o = mrd_q;
      else if (op_q == OP_PALL) addr_o[AP_BIT] = 1'b1;
    end
  end

  assign ba_o   = '0;
  assign cke_o  = cke_q;
  assign busy_o = (state_q != ST_IDLE);
  assign err_o  = err_q;

  AST_IDLE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ({ras_n_o, cas_n_o, we_n_o} == PIN_NOP && cs_n_o == '0)); // R1
  AST_WAIT_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> ({ras_n_o, cas_n_o, we_n_o} == PIN_NOP)); // R2
  AST_CMD_HAS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({ras_n_o, cas_n_o, we_n_o} != PIN_NOP) |-> (cs_n_o != '1)); // R3
  AST_PALL_A10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({ras_n_o, cas_n_o, we_n_o} == PIN_PALL) |-> addr_o[AP_BIT]); // R5
  AST_SREF_CKE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issuing && op_q == OP_SREF) |-> ((cke_o & tgt_q) == '0)); // R7
  AST_REJECT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_o) |=> err_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R9
endmodule

// File: tb/test_sdram_cmd_engine.sv
module test_sdram_cmd_engine;
  localparam int VW = 23;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_mode_i = '0;
  logic [1:0]  cmd_target_i = '0;
  logic [3:0]  cmd_rep_i = '0;
  logic [12:0] cmd_mrd_i = '0;
  logic [3:0]  t_rc_i = 4'd1, t_rp_i = 4'd2, t_mrd_i = 4'd3, t_xsr_i = 4'd4;
  logic        busy_o, err_o, ras_n_o, cas_n_o, we_n_o;
  logic [1:0]  cs_n_o, cke_o, ba_o;
  logic [12:0] addr_o;

  sdram_cmd_engine i_sdram_cmd_engine (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_mode_i, .cmd_target_i, .cmd_rep_i,
    .cmd_mrd_i, .t_rc_i, .t_rp_i, .t_mrd_i, .t_xsr_i, .busy_o, .err_o,
    .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o, .cke_o, .addr_o, .ba_o
  );

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [VW-1:0] exp_q[$];
  string         tag_q[$];
  logic [1:0]    cke_m = '0, sref_m = '0;

  // {busy, cs_n, ras/cas/we, cke, ba, addr}
  function automatic logic [VW-1:0] mk(logic b, logic [1:0] cs, logic [2:0] p,
                                       logic [1:0] ck, logic [12:0] a);
    return {b, cs, p, ck, 2'b00, a};
  endfunction

  function automatic logic [VW-1:0] actual();
    return {busy_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, cke_o, ba_o, addr_o};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor
  initial forever begin
    @(negedge clk_i);
    if (exp_q.size() > 0) begin
      logic [VW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, 32'(actual()), 32'(e));
    end
  end

  task automatic push(logic [VW-1:0] v, string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // Driver: computes the expected per-cycle pin trace from the requirements
  task automatic run_cmd(logic [2:0] md, logic [1:0] tg, logic [3:0] rp,
                         logic [12:0] mrd, string tag);
    int w, reps;
    logic [2:0] p;
    logic [12:0] a;
    bit xsr;
    @(negedge clk_i);
    cmd_valid_i = 1; cmd_mode_i = md; cmd_target_i = tg;
    cmd_rep_i = rp; cmd_mrd_i = mrd;
    @(posedge clk_i);
    #1 cmd_valid_i = 0;
    if (tg == 2'b00 || md == 3'd7) begin
      push(mk(0, 2'b00, 3'b111, cke_m, '0), tag);
      push(mk(0, 2'b00, 3'b111, cke_m, '0), tag);
    end else begin
      xsr = (md == 3'd0) && ((sref_m & tg) != 0);
      for (int d = 0; d < 2; d++) if (tg[d]) begin
        if (md == 3'd0 || md == 3'd1) cke_m[d] = 1;
        if (md == 3'd5 || md == 3'd6) cke_m[d] = 0;
        if (md == 3'd5) sref_m[d] = 1;
        if (md == 3'd0) sref_m[d] = 0;
      end
      w = 0; p = 3'b111; a = '0; reps = 1;
      case (md)
        3'd0: if (xsr) w = int'(t_xsr_i);
        3'd2: begin p = 3'b010; w = int'(t_rp_i); a = 13'h0400; end
        3'd3: begin p = 3'b001; w = int'(t_rc_i); reps = (rp == 0) ? 1 : int'(rp); end
        3'd4: begin p = 3'b000; w = int'(t_mrd_i); a = mrd; end
        3'd5: p = 3'b001;
        default: ;
      endcase
      for (int r = 0; r < reps; r++) begin
        push(mk(1, ~tg, p, cke_m, a), tag);
        for (int k = 0; k < w; k++) push(mk(1, 2'b00, 3'b111, cke_m, '0), tag);
      end
      push(mk(0, 2'b00, 3'b111, cke_m, '0), tag);
    end
    wait (exp_q.size() == 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    check("R1 reset pins", 32'(actual()), 32'(mk(0, 2'b00, 3'b111, 2'b00, '0)));
    check("R1 reset err", 32'(err_o), 32'd0);

    run_cmd(3'd1, 2'b11, 0, 0, "R7 clock enable both");
    run_cmd(3'd2, 2'b01, 0, 0, "R5 precharge all dev1 tRP");
    run_cmd(3'd3, 2'b11, 4'd3, 0, "R4 auto-refresh x3 R10");
    run_cmd(3'd3, 2'b10, 4'd0, 0, "R4 auto-refresh count 0");
    t_rc_i = 4'd0;
    run_cmd(3'd3, 2'b11, 4'd2, 0, "R4 back-to-back R10 tRC=1");
    run_cmd(3'd4, 2'b10, 0, 13'h0033, "R6 load mode dev2 tMRD");
    run_cmd(3'd5, 2'b01, 0, 0, "R7 self-refresh dev1");
    run_cmd(3'd0, 2'b10, 0, 0, "R8 normal dev2 no exit wait");
    run_cmd(3'd0, 2'b01, 0, 0, "R8 normal dev1 tXSR");
    run_cmd(3'd6, 2'b11, 0, 0, "R7 power-down both");
    run_cmd(3'd2, 2'b00, 0, 0, "R3 empty target ignored");
    check("R3 err after ignore", 32'(err_o), 32'd0);
    run_cmd(3'd7, 2'b11, 0, 0, "R3 code 7 ignored");
    run_cmd(3'd0, 2'b11, 0, 0, "R8 normal from power-down");

    // R9: write while busy
    t_rc_i = 4'd3;
    fork
      run_cmd(3'd3, 2'b11, 4'd2, 0, "R9 sequence unaltered by reject");
      begin
        @(posedge clk_i);
        @(negedge clk_i); @(negedge clk_i);
        cmd_valid_i = 1; cmd_mode_i = 3'd4; cmd_target_i = 2'b11; cmd_mrd_i = 13'h1fff;
        @(posedge clk_i);
        #1 cmd_valid_i = 0;
      end
    join
    @(negedge clk_i);
    check("R9 err set", 32'(err_o), 32'd1);
    repeat (3) @(negedge clk_i);
    check("R9 err sticky", 32'(err_o), 32'd1);
    check("R9 idle after", 32'(actual()), 32'(mk(0, 2'b00, 3'b111, cke_m, '0)));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule